// File: doc/BRIEF.md
# Masked Read-Modify-Write Access Engine

This block lets a host update part of a four-Dword entry held in one of four on-chip memories, without racing the hardware that owns those memories. The host loads write-data registers, a per-Dword mask and an entry index. It then writes a control word that picks the target memory and sets a start bit. The engine walks the Dwords of the entry from lowest to highest. For each Dword it reads the stored value into a read-data register. If that Dword's mask bit is set, it writes the host's data over it in the following cycle.

Two mode bits in the control word replace the mask for one pass. One forces every Dword to be overwritten. The other forces a pure read in which memory is left untouched. When both are set, the pass runs as a pure read. The start bit doubles as the busy flag, and it clears itself when the pass ends, together with both mode bits. While start is high, host writes to the control word are dropped. The host polls start before it reads the read-data registers.

Every memory port is a plain synchronous port with one-cycle read latency. At most one port is enabled in any cycle. The host register port is also plain: a write strobe with an address, and a combinational read path.

Top module: `rmw_engine`

## Requirements
- R1: After reset, every host register reads 0: control, mask, entry index, write data and read data. No memory port is enabled while start is 0.
- R2: The control word is at address 0x47 and uses these fields: bit 0 read-only mode, bit 1 overwrite-all mode, bit 2 stream direction, bit 3 start/busy, bits 5:4 memory select. A read returns 0 in bits 31:6.
- R3: The select and direction fields pick one port. Select 00 picks port 0, the processing RAM, whatever the direction bit holds. Select 01 with direction 0 picks port 1 (downstream), and with direction 1 picks port 2 (upstream). Select 10 or 11 picks port 3, the collection RAM.
- R4: A control write with bit 3 set starts a pass. The pass takes 8 cycles. For Dword i, in ascending order, cycle 2i+1 after the accepting edge issues a read of address {entry, i}. Cycle 2i+2 writes write-data register i to that address if effective mask bit i is 1, and is idle otherwise. Start reads 1 through cycle 8 and 0 from cycle 9.
- R5: After a pass, read-data register i (address 0x48+i) holds the value that Dword i had before the pass.
- R6: With overwrite-all (bit 1) set and read-only (bit 0) clear, the mask becomes all ones when the pass starts. All four Dwords are written. The mask (address 0x44, bits 3:0) reads 0xF afterwards, and bit 1 reads 0 afterwards.
- R7: With read-only (bit 0) set, the mask becomes all zeros when the pass starts. No port is written. The mask reads 0 afterwards, and bit 0 reads 0 afterwards.
- R8: With both mode bits set, the pass writes nothing. The mask reads 0 afterwards, and both mode bits read 0.
- R9: While start is 1, a host write to the control word is ignored. It starts no new pass and changes neither the target nor the fields.
- R10: A control write with bit 3 clear only stores the fields. Reading the word back returns them, and no port is enabled.
- R11: Write data (0x40+i), mask (0x44) and entry index (0x45, 6 bits) read back what was written. With no mode bit set, the pass uses the mask as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_addr | input | 8 | Host write address |
| hst_wdata | input | 32 | Host write data |
| hst_raddr | input | 8 | Host read address |
| hst_rdata | output | 32 | Host read data (combinational) |
| mem_en | output | 4 | Per-port enable (0 proc, 1 down, 2 up, 3 collection) |
| mem_we | output | 4 | Per-port write enable |
| mem_addr | output | 8 | Shared memory address {entry, Dword} |
| mem_wdata | output | 32 | Shared memory write data |
| mem_rdata | input | 128 | Read data of all ports, port p at bits 32p+31:32p |

## Verification
The hardest case to reach from the ports is a host write to the control word that lands in the middle of a pass. It has to arrive exactly while the busy bit is high, and it carries a different select, a start bit and mode bits. The bench counts falling edges from the accepting edge and places such a write in the third cycle of a pass. It then checks that the pass finished on the original port and that the stored fields were unchanged. A separate set of passes sets both mode bits at once, and the bench checks that every memory word is unchanged afterwards.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int HAW      = 8;
  localparam int NMEM     = 4;
  localparam int A_WDATA0 = 'h40;
  localparam int A_MASK   = 'h44;
  localparam int A_ENTRY  = 'h45;
  localparam int A_CTRL   = 'h47;
  localparam int A_RDATA0 = 'h48;

  typedef struct packed {
    logic [1:0] ramsel;
    logic       start;
    logic       updn;
    logic       wra;
    logic       rda;
  } ctrl_t;

  typedef enum logic [1:0] {
    TGT_PROC = 2'd0,
    TGT_DOWN = 2'd1,
    TGT_UP   = 2'd2,
    TGT_COLL = 2'd3
  } tgt_e;

  function automatic tgt_e tgt_of(ctrl_t c);
    if (c.ramsel[1])      return TGT_COLL;
    else if (c.ramsel[0]) return c.updn ? TGT_UP : TGT_DOWN;
    else                  return TGT_PROC;
  endfunction
endpackage

// File: rtl/rmw_regs.sv
module rmw_regs
  import rmw_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NDW = 4,
  parameter int EW  = 6,
  localparam int IW = $clog2(NDW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hst_wr,
  input  logic [HAW-1:0]           hst_addr,
  input  logic [DW-1:0]            hst_wdata,
  input  logic [HAW-1:0]           hst_raddr,
  output logic [DW-1:0]            hst_rdata,
  output logic                     go,
  input  logic                     done,
  input  logic                     cap_en,
  input  logic [IW-1:0]            cap_idx,
  input  logic [DW-1:0]            cap_data,
  output ctrl_t                    ctrl,
  output logic [NDW-1:0]           mask,
  output logic [NDW-1:0][DW-1:0]   wdat,
  output logic [EW-1:0]            entry
);
  logic [NDW-1:0][DW-1:0] rdat;
  logic ctrl_wr;

  assign ctrl_wr = hst_wr && (hst_addr == HAW'(A_CTRL)) && !ctrl.start;
  assign go      = ctrl_wr && hst_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      mask  <= '0;
      wdat  <= '0;
      rdat  <= '0;
      entry <= '0;
    end else begin
      if (done) begin
        ctrl.start <= 1'b0;
        ctrl.rda   <= 1'b0;
        ctrl.wra   <= 1'b0;
      end else if (ctrl_wr) begin
        ctrl <= ctrl_t'(hst_wdata[5:0]);
        if (hst_wdata[3]) begin
          if (hst_wdata[0])      mask <= '0;
          else if (hst_wdata[1]) mask <= '1;
        end
      end
      if (hst_wr && hst_addr == HAW'(A_MASK))  mask  <= hst_wdata[NDW-1:0];
      if (hst_wr && hst_addr == HAW'(A_ENTRY)) entry <= hst_wdata[EW-1:0];
      for (int i = 0; i < NDW; i++) begin
        if (hst_wr && hst_addr == HAW'(A_WDATA0 + i)) wdat[i] <= hst_wdata;
      end
      if (cap_en) rdat[cap_idx] <= cap_data;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (hst_raddr == HAW'(A_CTRL))  hst_rdata[5:0]     = ctrl;
    if (hst_raddr == HAW'(A_MASK))  hst_rdata[NDW-1:0] = mask;
    if (hst_raddr == HAW'(A_ENTRY)) hst_rdata[EW-1:0]  = entry;
    for (int i = 0; i < NDW; i++) begin
      if (hst_raddr == HAW'(A_WDATA0 + i)) hst_rdata = wdat[i];
      if (hst_raddr == HAW'(A_RDATA0 + i)) hst_rdata = rdat[i];
    end
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq #(
  parameter int NDW = 4,
  localparam int IW = $clog2(NDW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [NDW-1:0] mask,
  output logic           rd_req,
  output logic           wr_req,
  output logic           cap_en,
  output logic           done,
  output logic [IW-1:0]  idx
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WB} st_e;
  localparam logic [IW-1:0] LAST = IW'(NDW - 1);

  st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (go) begin
          st  <= S_RD;
          idx <= '0;
        end
        S_RD: st <= S_WB;
        S_WB: begin
          if (idx == LAST) st <= S_IDLE;
          else begin
            st  <= S_RD;
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req = (st == S_RD);
  assign cap_en = (st == S_WB);
  assign wr_req = (st == S_WB) && mask[idx];
  assign done   = (st == S_WB) && (idx == LAST);
endmodule

// File: rtl/rmw_portsel.sv
module rmw_portsel
  import rmw_pkg::*;
#(
  parameter int DW = 32
) (
  input  tgt_e                 tgt,
  input  logic                 rd_req,
  input  logic                 wr_req,
  input  logic [NMEM*DW-1:0]   mem_rdata,
  output logic [NMEM-1:0]      mem_en,
  output logic [NMEM-1:0]      mem_we,
  output logic [DW-1:0]        rdata
);
  for (genvar p = 0; p < NMEM; p++) begin : g_port
    logic hit;
    assign hit       = (tgt == tgt_e'(p));
    assign mem_en[p] = hit && (rd_req || wr_req);
    assign mem_we[p] = hit && wr_req;
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NMEM; p++) begin
      if (tgt == tgt_e'(p)) rdata = mem_rdata[p*DW +: DW];
    end
  end
endmodule

// File: rtl/rmw_engine.sv
module rmw_engine
  import rmw_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NDW = 4,
  parameter int AW  = 8,
  localparam int IW = $clog2(NDW),
  localparam int EW = AW - IW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hst_wr,
  input  logic [7:0]           hst_addr,
  input  logic [DW-1:0]        hst_wdata,
  input  logic [7:0]           hst_raddr,
  output logic [DW-1:0]        hst_rdata,
  output logic [3:0]           mem_en,
  output logic [3:0]           mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [4*DW-1:0]      mem_rdata
);
  ctrl_t                  ctrl;
  logic [NDW-1:0]         mask;
  logic [NDW-1:0][DW-1:0] wdat;
  logic [EW-1:0]          entry;
  logic                   go, done, rd_req, wr_req, cap_en;
  logic [IW-1:0]          idx;
  logic [DW-1:0]          sel_rdata;
  tgt_e                   tgt;

  assign tgt       = tgt_of(ctrl);
  assign mem_addr  = {entry, idx};
  assign mem_wdata = wdat[idx];

  rmw_regs #(.DW(DW), .NDW(NDW), .EW(EW)) u_regs (
    .clk, .rst_n, .hst_wr, .hst_addr, .hst_wdata, .hst_raddr, .hst_rdata,
    .go, .done, .cap_en, .cap_idx(idx), .cap_data(sel_rdata),
    .ctrl, .mask, .wdat, .entry
  );

  rmw_seq #(.NDW(NDW)) u_seq (
    .clk, .rst_n, .go, .mask, .rd_req, .wr_req, .cap_en, .done, .idx
  );

  rmw_portsel #(.DW(DW)) u_psel (
    .tgt, .rd_req, .wr_req, .mem_rdata, .mem_en, .mem_we, .rdata(sel_rdata)
  );
endmodule

// File: rtl/rmw_engine_chk.sv
module rmw_engine_chk
  import rmw_pkg::*;
#(
  parameter int NDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input ctrl_t          ctrl,
  input logic [NDW-1:0] mask,
  input logic [3:0]     mem_en,
  input logic [3:0]     mem_we
);
  // R3: only one port is active at a time
  a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_en));

  // R4: a write strobe never appears without its enable
  a_r4_we_has_en: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we & ~mem_en) == 4'b0);

  // R1, R10: no memory traffic unless busy
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.start |-> mem_en == 4'b0);

  // R7, R8: read-only mode never writes
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.start && ctrl.rda) |-> mem_we == 4'b0);

  // R6: overwrite-all keeps every mask bit set during the pass
  a_r6_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.start && ctrl.wra && !ctrl.rda) |-> (&mask));

  // R9: control fields frozen while busy
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.start) && ctrl.start) |-> ctrl == $past(ctrl));

  // R6, R7: mode bits cleared with start
  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.start) |-> (!ctrl.rda && !ctrl.wra));
endmodule

bind rmw_engine rmw_engine_chk #(.NDW(NDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mask(mask),
  .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/sim_rmw_engine.sv
`timescale 1ns/1ps
module sim_rmw_engine;
  localparam int DW = 32, NDW = 4, AW = 8, EW = 6, DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_wr = 1'b0;
  logic [7:0] hst_addr = '0, hst_raddr = '0;
  logic [DW-1:0] hst_wdata = '0, hst_rdata;
  logic [3:0] mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [4*DW-1:0] mem_rdata;

  logic [DW-1:0] mem  [4][DEPTH];
  logic [DW-1:0] emem [4][DEPTH];
  logic [DW-1:0] rq   [4];

  int tests = 0, fails = 0, pass_no = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rmw_engine #(.DW(DW), .NDW(NDW), .AW(AW)) u0 (
    .clk, .rst_n, .hst_wr, .hst_addr, .hst_wdata, .hst_raddr, .hst_rdata,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
  );

  assign mem_rdata = {rq[3], rq[2], rq[1], rq[0]};

  always @(posedge clk) begin
    for (int p = 0; p < 4; p++) begin
      if (mem_en[p]) begin
        if (mem_we[p]) mem[p][mem_addr] <= mem_wdata;
        rq[p] <= mem[p][mem_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input int a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = 8'(a); hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hrd(input int a, output logic [31:0] d);
    @(negedge clk);
    hst_raddr = 8'(a);
    #1 d = hst_rdata;
  endtask

  function automatic int tgt_of(input int sel, input int updn);
    if (sel >= 2) return 3;
    if (sel == 1) return updn ? 2 : 1;
    return 0;
  endfunction

  task automatic cmp_mem(input string tag);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < DEPTH; w++)
        if (mem[p][w] !== emem[p][w]) begin
          if (bad == 0) begin a = mem[p][w]; e = emem[p][w]; end
          bad++;
        end
    chk(bad == 0, tag, a, e);
  endtask

  // one pass; protect=1 injects a control write in cycle 3
  task automatic run_pass(input int sel, input int updn, input bit wra, input bit rda,
                          input logic [3:0] msk, input int ent, input bit protect);
    int t = tgt_of(sel, updn);
    logic [3:0] em = rda ? 4'h0 : (wra ? 4'hF : msk);
    logic [31:0] wd [NDW], old [NDW], v;
    logic [31:0] cw;
    bit seq_ok = 1, busy_ok = 1;
    logic [31:0] bad_act = 0, bad_exp = 0;
    pass_no++;
    for (int i = 0; i < NDW; i++) begin
      wd[i] = 32'h5000_0000 ^ (pass_no << 12) ^ (t << 8) ^ i;
      hwr('h40 + i, wd[i]);
      old[i] = emem[t][{ent[EW-1:0], 2'(i)}];
    end
    hwr('h44, {28'b0, msk});
    hwr('h45, ent);
    cw = (sel << 4) | (updn << 2) | 32'h8 | (wra << 1) | rda;
    @(negedge clk);
    hst_raddr = 8'h47;
    hst_wr = 1'b1; hst_addr = 8'h47; hst_wdata = cw;
    for (int c = 1; c <= 9; c++) begin
      int i = (c - 1) / 2;
      logic [3:0] een, ewe;
      @(negedge clk);
      #1;
      if (c <= 8) begin
        een = 4'(1 << t);
        ewe = 4'h0;
        if (c % 2 == 0) begin
          if (!em[i]) een = 4'h0;
          else ewe = een;
        end
        if (mem_en !== een || mem_we !== ewe ||
            (een != 0 && mem_addr !== {ent[EW-1:0], 2'(i)}) ||
            (ewe != 0 && mem_wdata !== wd[i])) begin
          if (seq_ok) begin bad_act = {c[7:0], mem_addr, 4'(mem_en), 4'(mem_we)}; bad_exp = {c[7:0], ent[5:0], 2'(i), een, ewe}; end
          seq_ok = 0;
        end
        if (hst_rdata[3] !== 1'b1) busy_ok = 0;
      end else begin
        chk(hst_rdata === ((sel << 4) | (updn << 2)), "R4/R6/R7 start and mode bits self-clear",
            hst_rdata, (sel << 4) | (updn << 2));
      end
      hst_wr = 1'b0;
      if (protect && c == 3) begin
        hst_wr = 1'b1; hst_addr = 8'h47;
        hst_wdata = 32'h0000_003B ^ (sel << 4);
      end
    end
    chk(seq_ok, "R4 Dword order, address and write slots", bad_act, bad_exp);
    chk(busy_ok, "R4 start reads 1 during pass", 0, 1);
    for (int i = 0; i < NDW; i++) if (em[i]) emem[t][{ent[EW-1:0], 2'(i)}] = wd[i];
    cmp_mem(rda ? "R7/R8 memory unchanged" : (protect ? "R9 pass kept its target" : "R3/R6 memory contents"));
    for (int i = 0; i < NDW; i++) begin
      hrd('h48 + i, v);
      chk(v === old[i], "R5 read-data register", v, old[i]);
    end
    hrd('h44, v);
    chk(v === {28'b0, em}, "R6/R7/R8/R11 mask after pass", v, {28'b0, em});
  endtask

  initial begin
    logic [31:0] v;
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < DEPTH; w++) begin
        mem[p][w]  = 32'hA000_0000 + (p << 16) + w;
        emem[p][w] = 32'hA000_0000 + (p << 16) + w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    hrd('h47, v); chk(v === 0, "R1 control after reset", v, 0);
    hrd('h44, v); chk(v === 0, "R1 mask after reset", v, 0);
    hrd('h45, v); chk(v === 0, "R1 entry after reset", v, 0);
    for (int i = 0; i < NDW; i++) begin
      hrd('h40 + i, v); chk(v === 0, "R1 write data after reset", v, 0);
      hrd('h48 + i, v); chk(v === 0, "R1 read data after reset", v, 0);
    end
    chk(mem_en === 0, "R1 ports idle after reset", mem_en, 0);

    // R2, R10: fields stored without start, upper bits read 0
    hwr('h47, 32'hFFFF_FFF7);
    hrd('h47, v); chk(v === 32'h37, "R2/R10 field layout, bits 31:6 zero", v, 32'h37);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(mem_en === 0, "R10 no pass without start", mem_en, 0);
    end
    cmp_mem("R10 memory untouched");
    hwr('h47, 0);

    // R11 readback
    hwr('h45, 32'hFFFF_FFE9);
    hrd('h45, v); chk(v === 32'h29, "R11 entry readback 6 bits", v, 32'h29);
    hwr('h44, 32'hFFFF_FFF5);
    hrd('h44, v); chk(v === 32'h5, "R11 mask readback 4 bits", v, 32'h5);

    // R3, R4, R11: every select/direction with every mask
    for (int sel = 0; sel < 4; sel++)
      for (int ud = 0; ud < 2; ud++)
        for (int m = 0; m < 16; m++)
          run_pass(sel, ud, 0, 0, 4'(m), (sel * 32 + ud * 16 + m * 3) % 64, 0);

    // R6, R7, R8: mode overrides against several masks
    for (int m = 0; m < 16; m += 5)
      for (int sel = 0; sel < 4; sel++) begin
        run_pass(sel, m & 1, 1, 0, 4'(m), (m + sel * 7) % 64, 0);
        run_pass(sel, m & 1, 0, 1, 4'(m), (m + sel * 11) % 64, 0);
        run_pass(sel, m & 1, 1, 1, 4'(m), (m + sel * 13) % 64, 0);
      end

    // R9: control write during a pass is dropped
    run_pass(0, 0, 0, 0, 4'hA, 5, 1);
    run_pass(1, 1, 0, 1, 4'h6, 9, 1);
    run_pass(2, 0, 1, 0, 4'h1, 17, 1);
    hrd('h47, v); chk(v === 32'h20, "R9 fields after protected pass", v, 32'h20);
    repeat (4) @(negedge clk);
    chk(mem_en === 0, "R9 no second pass started", mem_en, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule